// File: doc/BRIEF.md
# USB Bit-Level Receive Engine

This block turns a stream of sampled bus line states into received bytes for a link-layer engine. A recovery stage outside the block hands it one two-bit line symbol per bit time, marked by a one-clock strobe. The block first hunts for the synchronisation pattern. It then undoes the NRZI line coding and strips stuffed bits. It packs the data bits into bytes, least significant bit first, and ends the packet on a single-ended-zero symbol or on a coding violation.

The link layer sees three flags and a data byte. `rx_active` frames the packet from SYNC to its end. `rx_valid` marks the one clock in which `rx_data` holds a freshly completed byte. `rx_error` flags a packet that was aborted by a stuffing violation or an illegal line state. Byte width, stuffing run length, minimum SYNC length and bit order are parameters.

Top module: `usb_rx_engine`

## Requirements
- R1: `line_st` is coded as follows: 2'b00 is SE0, 2'b01 is J (D+ high), 2'b10 is K (D- high), 2'b11 is SE1. Bit 0 follows D+ and bit 1 follows D-.
- R2: While idle, the block recognises SYNC as at least SYNC_MIN_ALT (default 4) consecutive J/K changes followed by two K symbols in a row. `rx_active` rises in the clock after the strobe that carries the second K. A shorter run of changes does not start a packet.
- R3: During a packet, a J/K symbol equal to the previous one decodes to 1 and one that differs decodes to 0. Decoded bits fill bytes least significant bit first. `rx_data` holds the completed byte whenever `rx_valid` is high.
- R4: `rx_valid` is a single-clock pulse for each completed byte. It occurs only while `rx_active` is high.
- R5: After STUFF_RUN (default 6) consecutive decoded 1 bits, the next decoded 0 is discarded. The run count starts at zero with the first bit after SYNC, and stuffing may straddle byte boundaries.
- R6: A decoded 1 that follows STUFF_RUN consecutive 1 bits ends the packet. At that clock edge `rx_active` falls and `rx_error` pulses high for one clock. No byte is delivered for the partial data.
- R7: An SE0 symbol during a packet ends it. `rx_active` falls at that edge, `rx_error` stays low, and any partially assembled byte is dropped without an `rx_valid` pulse.
- R8: An SE1 symbol during a packet ends it as an error, with the same output behaviour as R6.
- R9: While `rst_n` is low, `rx_active`, `rx_valid` and `rx_error` are all low.
- R10: Line symbols presented while `bit_en` is low are ignored. They neither start, end nor alter a packet, and no output flag changes in the clock that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One-clock strobe marking a valid line sample |
| line_st | input | 2 | Sampled line state, coded per R1 |
| rx_active | output | 1 | High from SYNC detection until packet end |
| rx_valid | output | 1 | One-clock pulse: `rx_data` holds a new byte |
| rx_error | output | 1 | One-clock pulse: packet aborted by an error |
| rx_data | output | BYTE_W | Last completed received byte |

## Verification
Packets of one to five bytes are sent through a bench-side NRZI and stuffing encoder. Mixed values such as 0xA5 check bit order. Runs of 0xFF force stuffed zeros inside bytes and across byte boundaries, which separates a correct destuffer from one that drops or keeps the wrong bit. Aborts are applied in the middle of a byte: seven equal symbols, an SE1, and an early SE0. They show whether the error and the end-of-packet paths behave differently and whether partial bytes leak out. A run of changes that is too short to count as SYNC, SYNC toggling with the strobe held low, and garbage on the line between strobes check that only strobed symbols reach the decoder.

// File: rtl/usb_rx_pkg.sv
package usb_rx_pkg;

   typedef enum logic [1:0] {
      SYM_SE0 = 2'b00,
      SYM_J   = 2'b01,
      SYM_K   = 2'b10,
      SYM_SE1 = 2'b11
   } line_sym_t;

   typedef enum logic {
      RX_HUNT = 1'b0,
      RX_BUSY = 1'b1
   } rx_state_t;

endpackage

// File: rtl/usb_rx_nrzi.sv
module usb_rx_nrzi
   import usb_rx_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      strobe,
   input  line_sym_t sym,
   output line_sym_t prev_sym,
   output logic      same_sym
);

   line_sym_t prev_q;

   // the bus idles in J, so that is the reference after reset
   always_ff @(posedge clk) begin
      if (!rst_n)
         prev_q <= SYM_J;
      else if (strobe)
         prev_q <= sym;
   end

   assign prev_sym = prev_q;
   assign same_sym = (sym == prev_q);

   // R10
   prev_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe |=> $stable(prev_q));

endmodule

// File: rtl/usb_rx_sync_det.sv
module usb_rx_sync_det
   import usb_rx_pkg::*;
#(
   parameter int MIN_ALT = 4
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      strobe,
   input  logic      hunting,
   input  line_sym_t sym,
   input  line_sym_t prev_sym,
   output logic      sync_hit
);

   localparam int CW = $clog2(MIN_ALT + 1);

   if (MIN_ALT < 1) begin : g_bad_min
      $error("usb_rx_sync_det: MIN_ALT must be at least 1");
   end

   logic [CW-1:0] alt_q;
   logic          sym_jk, prev_jk, toggled, alt_full;

   assign sym_jk   = (sym == SYM_J) || (sym == SYM_K);
   assign prev_jk  = (prev_sym == SYM_J) || (prev_sym == SYM_K);
   assign toggled  = sym_jk && prev_jk && (sym != prev_sym);
   assign alt_full = (alt_q == CW'(MIN_ALT));

   assign sync_hit = hunting && strobe && alt_full &&
                     (sym == SYM_K) && (prev_sym == SYM_K);

   always_ff @(posedge clk) begin
      if (!rst_n || !hunting)
         alt_q <= '0;
      else if (strobe) begin
         if (!toggled)
            alt_q <= '0;
         else if (!alt_full)
            alt_q <= alt_q + 1'b1;
      end
   end

   // R2
   alt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      alt_q <= CW'(MIN_ALT));

endmodule

// File: rtl/usb_rx_destuff.sv
module usb_rx_destuff #(
   parameter int RUN_LEN = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic bit_stb,
   input  logic bit_in,
   output logic drop_bit,
   output logic stuff_err
);

   localparam int CW = $clog2(RUN_LEN + 1);

   if (RUN_LEN < 1) begin : g_bad_run
      $error("usb_rx_destuff: RUN_LEN must be at least 1");
   end

   logic [CW-1:0] ones_q;
   logic          at_limit;

   assign at_limit  = (ones_q == CW'(RUN_LEN));
   assign drop_bit  = bit_stb && at_limit && !bit_in;
   assign stuff_err = bit_stb && at_limit &&  bit_in;

   always_ff @(posedge clk) begin
      if (!rst_n || clear)
         ones_q <= '0;
      else if (bit_stb) begin
         if (at_limit || !bit_in)
            ones_q <= '0;
         else
            ones_q <= ones_q + 1'b1;
      end
   end

   // R5
   run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ones_q <= CW'(RUN_LEN));

   // R5
   drop_resets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drop_bit |=> ones_q == '0);

endmodule

// File: rtl/usb_rx_byte_asm.sv
module usb_rx_byte_asm #(
   parameter int BYTE_W    = 8,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              take,
   input  logic              bit_in,
   output logic              byte_done,
   output logic [BYTE_W-1:0] byte_q
);

   localparam int CW = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;

   if (BYTE_W < 2) begin : g_bad_w
      $error("usb_rx_byte_asm: BYTE_W must be at least 2");
   end

   logic [BYTE_W-1:0] sh_q, sh_nx;
   logic [CW-1:0]     cnt_q;
   logic              last;

   if (LSB_FIRST) begin : g_lsb
      assign sh_nx = {bit_in, sh_q[BYTE_W-1:1]};
   end else begin : g_msb
      assign sh_nx = {sh_q[BYTE_W-2:0], bit_in};
   end

   assign last = (cnt_q == CW'(BYTE_W - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q      <= '0;
         cnt_q     <= '0;
         byte_q    <= '0;
         byte_done <= 1'b0;
      end else begin
         byte_done <= 1'b0;
         if (clear)
            cnt_q <= '0;
         else if (take) begin
            sh_q  <= sh_nx;
            cnt_q <= last ? '0 : cnt_q + 1'b1;
            if (last) begin
               byte_q    <= sh_nx;
               byte_done <= 1'b1;
            end
         end
      end
   end

   // R4
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      byte_done |=> !byte_done);

endmodule

// File: rtl/usb_rx_engine.sv
module usb_rx_engine
   import usb_rx_pkg::*;
#(
   parameter int BYTE_W       = 8,
   parameter int STUFF_RUN    = 6,
   parameter int SYNC_MIN_ALT = 4,
   parameter bit LSB_FIRST    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_en,
   input  logic [1:0]        line_st,
   output logic              rx_active,
   output logic              rx_valid,
   output logic              rx_error,
   output logic [BYTE_W-1:0] rx_data
);

   line_sym_t sym, prev_sym;
   rx_state_t state_q;
   logic      same_sym, hunting, sync_hit;
   logic      busy_stb, sym_jk, bit_stb, eop, bad_lvl;
   logic      drop_bit, stuff_err, take, err_q;

   assign sym      = line_sym_t'(line_st);
   assign hunting  = (state_q == RX_HUNT);
   assign busy_stb = bit_en && !hunting;
   assign sym_jk   = (sym == SYM_J) || (sym == SYM_K);
   assign bit_stb  = busy_stb && sym_jk;
   assign eop      = busy_stb && (sym == SYM_SE0);
   assign bad_lvl  = busy_stb && (sym == SYM_SE1);
   assign take     = bit_stb && !drop_bit && !stuff_err;

   usb_rx_nrzi u_nrzi (
      .clk      (clk),
      .rst_n    (rst_n),
      .strobe   (bit_en),
      .sym      (sym),
      .prev_sym (prev_sym),
      .same_sym (same_sym)
   );

   usb_rx_sync_det #(.MIN_ALT(SYNC_MIN_ALT)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .strobe   (bit_en),
      .hunting  (hunting),
      .sym      (sym),
      .prev_sym (prev_sym),
      .sync_hit (sync_hit)
   );

   usb_rx_destuff #(.RUN_LEN(STUFF_RUN)) u_destuff (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (hunting),
      .bit_stb   (bit_stb),
      .bit_in    (same_sym),
      .drop_bit  (drop_bit),
      .stuff_err (stuff_err)
   );

   usb_rx_byte_asm #(.BYTE_W(BYTE_W), .LSB_FIRST(LSB_FIRST)) u_asm (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (hunting),
      .take      (take),
      .bit_in    (same_sym),
      .byte_done (rx_valid),
      .byte_q    (rx_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= RX_HUNT;
         err_q   <= 1'b0;
      end else begin
         err_q <= bad_lvl || stuff_err;
         if (hunting && sync_hit)
            state_q <= RX_BUSY;
         else if (eop || bad_lvl || stuff_err)
            state_q <= RX_HUNT;
      end
   end

   assign rx_active = (state_q == RX_BUSY);
   assign rx_error  = err_q;

   // R6
   err_ends_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_error |-> !rx_active);

   // R6
   err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_error |=> !rx_error);

   // R4
   valid_in_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> rx_active);

   // R10
   no_strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> $stable(rx_active) && !rx_valid && !rx_error);

   // R2
   sync_on_k_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_active) |-> $past(bit_en) && $past(line_st) == 2'b10);

endmodule

// File: tb/usb_rx_engine_test.sv
`timescale 1ns/1ps
module usb_rx_engine_test;

   localparam logic [1:0] S_SE0 = 2'b00;
   localparam logic [1:0] S_J   = 2'b01;
   localparam logic [1:0] S_K   = 2'b10;
   localparam logic [1:0] S_SE1 = 2'b11;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_en = 1'b0;
   logic [1:0] line_st = S_J;
   logic       rx_active, rx_valid, rx_error;
   logic [7:0] rx_data;

   int         n_vec = 0;
   int         n_bad = 0;
   bit         finished = 1'b0;

   // captured at the end of each strobed symbol
   logic       v_act, v_err;
   logic [7:0] rcv [0:15];
   int         nrcv;
   bit         wide;
   bit         use_gap = 1'b0;
   logic [1:0] gap_sym = S_SE0;
   logic [1:0] cur;
   int         ones;

   usb_rx_engine uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_en    (bit_en),
      .line_st   (line_st),
      .rx_active (rx_active),
      .rx_valid  (rx_valid),
      .rx_error  (rx_error),
      .rx_data   (rx_data)
   );

   always #2.5 clk = ~clk;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // one strobed symbol followed by one idle clock
   task automatic send_sym(input logic [1:0] s);
      line_st = s;
      bit_en  = 1'b1;
      @(negedge clk);
      v_act = rx_active;
      v_err = rx_error;
      if (rx_valid && nrcv < 16) begin
         rcv[nrcv] = rx_data;
         nrcv++;
      end
      bit_en = 1'b0;
      if (use_gap) line_st = gap_sym;
      @(negedge clk);
      if (rx_valid || rx_error) wide = 1'b1;
   endtask

   task automatic flip();
      cur = (cur == S_J) ? S_K : S_J;
   endtask

   // bench-side NRZI encoder with stuffing
   task automatic send_bit(input bit b);
      if (b) ones++;
      else begin
         flip();
         ones = 0;
      end
      send_sym(cur);
      if (ones == 6) begin
         flip();
         send_sym(cur);
         ones = 0;
      end
   endtask

   task automatic send_sync();
      send_sym(S_J);
      send_sym(S_J);
      for (int i = 0; i < 3; i++) begin
         send_sym(S_K);
         send_sym(S_J);
      end
      send_sym(S_K);
      send_sym(S_K);
      cur  = S_K;
      ones = 0;
   endtask

   task automatic pkt_roundtrip(input string req, input logic [39:0] pl, input int n);
      nrcv = 0;
      wide = 1'b0;
      send_sync();
      chk({req, " R2 active after sync"}, v_act, 1);
      for (int i = 0; i < n; i++)
         for (int j = 0; j < 8; j++)
            send_bit(pl[8*i + j]);
      chk({req, " active before eop"}, v_act, 1);
      send_sym(S_SE0);
      chk({req, " R7 eop ends packet"}, {v_act, v_err}, 2'b00);
      send_sym(S_SE0);
      send_sym(S_J);
      cur = S_J;
      chk({req, " R4 byte count"}, nrcv, n);
      for (int i = 0; i < n && i < nrcv; i++)
         chk({req, " R3 byte value"}, rcv[i], pl[8*i +: 8]);
      chk({req, " R4 single-clock pulses"}, wide, 0);
   endtask

   task automatic t_reset();
      chk("R9 outputs in reset", {rx_active, rx_valid, rx_error}, 3'b000);
   endtask

   task automatic t_basic();
      pkt_roundtrip("R3 single byte", 40'hA5, 1);
      pkt_roundtrip("R3 three bytes", 40'h5A_81_3C, 3);
   endtask

   task automatic t_stuffing();
      pkt_roundtrip("R5 stuffed run", 40'hF0_3F_00_FF_FF, 5);
      pkt_roundtrip("R5 all ones", 40'hFF_FF_FF, 3);
   endtask

   task automatic t_strobe_gaps();
      use_gap = 1'b1;
      gap_sym = S_SE0;
      pkt_roundtrip("R10 SE0 between strobes", 40'hC3_7E, 2);
      gap_sym = S_SE1;
      pkt_roundtrip("R10 SE1 between strobes", 40'h96_E1, 2);
      use_gap = 1'b0;
      // a full SYNC shape with the strobe held low
      for (int i = 0; i < 4; i++) begin
         line_st = S_K; @(negedge clk);
         line_st = S_J; @(negedge clk);
      end
      line_st = S_K; @(negedge clk);
      line_st = S_K; @(negedge clk);
      chk("R10 unstrobed sync ignored", rx_active, 0);
      line_st = S_J;
      @(negedge clk);
   endtask

   task automatic t_stuff_error();
      nrcv = 0;
      wide = 1'b0;
      send_sync();
      for (int i = 0; i < 6; i++) send_sym(S_K);
      chk("R6 six ones accepted", {v_act, v_err}, 2'b10);
      send_sym(S_K);
      chk("R6 seventh one aborts", {v_act, v_err}, 2'b01);
      chk("R6 error single clock", wide, 0);
      chk("R6 no partial byte", nrcv, 0);
      send_sym(S_J);
      send_sym(S_J);
      cur = S_J;
   endtask

   task automatic t_se1_error();
      nrcv = 0;
      send_sync();
      send_bit(1'b0);
      send_bit(1'b1);
      send_bit(1'b0);
      send_sym(S_SE1);
      chk("R8 SE1 aborts with error", {v_act, v_err}, 2'b01);
      send_sym(S_J);
      chk("R8 error cleared", {rx_active, rx_error}, 2'b00);
      send_sym(S_J);
      cur = S_J;
   endtask

   task automatic t_partial_drop();
      nrcv = 0;
      send_sync();
      for (int i = 0; i < 5; i++) send_bit(i[0]);
      send_sym(S_SE0);
      chk("R7 early eop no error", {v_act, v_err}, 2'b00);
      chk("R7 partial byte dropped", nrcv, 0);
      send_sym(S_SE0);
      send_sym(S_J);
      cur = S_J;
   endtask

   task automatic t_short_sync();
      bit seen;
      seen = 1'b0;
      send_sym(S_J);
      send_sym(S_J);
      send_sym(S_K); seen |= v_act;
      send_sym(S_J); seen |= v_act;
      send_sym(S_K); seen |= v_act;
      send_sym(S_K); seen |= v_act;
      send_sym(S_J); seen |= v_act;
      send_sym(S_J); seen |= v_act;
      chk("R2 short sync rejected", seen, 0);
      cur = S_J;
      pkt_roundtrip("R2 sync after rejection", 40'h0F, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 idle J keeps block quiet", {rx_active, rx_valid, rx_error}, 3'b000);
      cur  = S_J;
      ones = 0;
      t_basic();
      t_stuffing();
      t_strobe_gaps();
      t_stuff_error();
      t_se1_error();
      t_partial_drop();
      t_short_sync();
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_vec++;
         n_bad++;
         $display("FAIL watchdog: actual running expected done");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule